// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers the interrupt requests of an 8-bit processor core and tells the core which one to serve next. There are sixteen sources. The first is a start-up service that follows reset. Fourteen are maskable hardware sources: four edge-sensitive pins, one keyboard wake-up group and nine on-chip event strobes from the serial ports and timers. The last is a software break strobe from the core. Each maskable source has a request flag, which only hardware can set, and an enable flag. A single global disable flag gates all of the maskable sources at once. The break source and the start-up service ignore every mask.

The core sees a level `irq` and, with it, a 4-bit source index and a 16-bit vector address. Both stay stable until the core pulses `ack`. On that pulse the block clears the request it was offering and sets the global disable flag. Saving the program counter and status, and fetching the vector contents, stay in the core. Software reaches the flags through a small byte-wide register port.

The control is a three-state machine. `ST_RST_SVC` is entered at reset and offers source 0 until `ack`, which takes it to `ST_IDLE` (transition *boot_ack*). `ST_IDLE` moves to `ST_REQ` when any source qualifies and latches the winner (transition *grant*). `ST_REQ` returns to `ST_IDLE` either on `ack` (transition *serve*) or when the latched source stops qualifying because software cleared, disabled or masked it (transition *withdraw*).

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq`=1, `src_idx`=0 and `vector`=0xFFFC until the first `ack`, after which `irq` drops. Reset leaves all request and enable bits at 0, the edge selects at 0 and the global disable flag at 1.
- R2: A maskable source can raise `irq` only while its request bit is 1, its enable bit is 1 and the global disable flag (register 4 bit 0) is 0.
- R3: Register map (3-bit address, 8-bit data). Address 0 holds the request bits of sources 1..8 in bits 0..7. Address 1 holds the request bits of sources 9..14 in bits 0..5. Addresses 2 and 3 hold the enable bits with the same layout. Address 4 holds the global disable flag in bit 0 and the edge selects of INT0, INT1, CNTR0 and CNTR1 in bits 1..4. Writing 0 to a request bit clears it; writing 1 leaves it unchanged.
- R4: A `brk` strobe makes source 15 pending, and it is offered whatever the enable bits and the disable flag hold.
- R5: When several sources qualify at the same time, the lowest index is offered. The index order is: 1 INT0 pin, 2 INT1 pin, 3 serial1 receive, 4 serial1 transmit, 5 timer X, 6 timer Y, 7 timer 2, 8 timer 3, 9 serial2 receive, 10 serial2 transmit, 11 CNTR0 pin, 12 CNTR1 pin, 13 timer 1, 14 key wake-up, 15 break.
- R6: `vector` equals 0xFFFC − 2·`src_idx` for indices 0..14, and 0xFFDC for index 15.
- R7: `ack` while `irq`=1 clears the request of the offered source and sets the global disable flag.
- R8: Each of the four pins (`pin_ext` bit 0..3 = INT0, INT1, CNTR0, CNTR1) is synchronised through two flops. With its edge select at 1 it requests on a rising edge; with it at 0 it requests on a falling edge.
- R9: Toggling an edge select while the pin holds a level that matches the new active edge sets that pin's request.
- R10: The key wake-up request (source 14) is set when the AND of all `key_in` bits falls from 1 to 0, and not when it rises.
- R11: A hardware set and a software clear of the same request bit in one cycle leave the bit set.
- R12: While `irq`=1 and no `ack` arrives, `src_idx` and `vector` hold, even if a higher-priority source becomes pending.

Internal event strobe mapping: `int_evt` bits 0..7 drive sources 3..10, and bit 8 drives source 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_ext | input | 4 | Edge-sensitive pins INT0, INT1, CNTR0, CNTR1 |
| key_in | input | KEY_W | Keyboard wake-up port levels |
| int_evt | input | 9 | On-chip event strobes (serial, timers) |
| brk | input | 1 | Software break strobe from the core |
| ack | input | 1 | Core accepts the offered source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | A source is being offered |
| vector | output | 16 | Vector low address of the offered source |
| src_idx | output | 4 | Index of the offered source |

## Verification
Two functions can fall in the same cycle. A hardware event can set a request bit in the very cycle in which software writes 0 to clear it. The bench provokes this by driving an event strobe and a clearing register write on the same clock edge, and it judges the outcome by reading the request register back and expecting the bit to be set. A second collision pairs `ack` with a new higher-priority arrival: the offered vector must stay stable up to the `ack`, and the newcomer must be offered only after software clears the disable flag.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    localparam int N_SRC   = 16;
    localparam int IDX_W   = 4;
    localparam int N_MASK  = 14;
    localparam int N_PIN   = 4;
    localparam int N_EVT   = 9;
    localparam logic [IDX_W-1:0] IDX_BRK = 4'd15;
    localparam logic [15:0] VEC_TOP = 16'hFFFC;
    localparam logic [15:0] VEC_BRK = 16'hFFDC;

    typedef enum logic [1:0] {
        ST_RST_SVC,
        ST_IDLE,
        ST_REQ
    } ivc_state_e;

    function automatic logic [15:0] vec_of(input logic [IDX_W-1:0] idx);
        if (idx == IDX_BRK) return VEC_BRK;
        return VEC_TOP - {11'd0, idx, 1'b0};
    endfunction
endpackage

// File: rtl/ivc_sync.sv
module ivc_sync #(
    parameter int W       = 1,
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= {W{RST_VAL}};
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  qual,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |qual;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (qual[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int KEY_W  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       pin_ext,
    input  logic [KEY_W-1:0] key_in,
    input  logic [8:0]       int_evt,
    input  logic             brk,
    input  logic             ack,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             irq,
    output logic [15:0]      vector,
    output logic [3:0]       src_idx
);
    ivc_state_e        state_q, state_d;
    logic [IDX_W-1:0]  lat_q;
    logic [N_MASK-1:0] req_q, req_d, en_q;
    logic [N_PIN-1:0]  esel_q, pin_s, pol, pol_prev_q, pin_evt;
    logic              gdis_q, brk_pend_q;
    logic [KEY_W-1:0]  key_s;
    logic              key_and, key_prev_q, key_fall;
    logic [N_MASK-1:0] hw_set;
    logic [N_SRC-1:0]  qual;
    logic              win_any;
    logic [IDX_W-1:0]  win_idx;
    logic              ack_take;

    // ---------------- pin synchronisers and edge detection ----------------
    ivc_sync #(.W(N_PIN), .STAGES(STAGES), .RST_VAL(1'b0)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_ext), .dout(pin_s));

    ivc_sync #(.W(KEY_W), .STAGES(STAGES), .RST_VAL(1'b1)) u_key_sync (
        .clk(clk), .rst_n(rst_n), .din(key_in), .dout(key_s));

    for (genvar p = 0; p < N_PIN; p++) begin : g_pin
        // polarity applied first, so a select change is seen as an edge
        assign pol[p]     = esel_q[p] ? pin_s[p] : ~pin_s[p];
        assign pin_evt[p] = pol[p] & ~pol_prev_q[p];
    end

    assign key_and  = &key_s;
    assign key_fall = key_prev_q & ~key_and;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_prev_q <= '1;
            key_prev_q <= 1'b1;
        end else begin
            pol_prev_q <= pol;
            key_prev_q <= key_and;
        end
    end

    // source k lives in bit k-1 of the maskable vectors
    assign hw_set = {key_fall, int_evt[8], pin_evt[3], pin_evt[2],
                     int_evt[7:0], pin_evt[1], pin_evt[0]};

    // ---------------- qualification and priority ----------------
    assign qual = {brk_pend_q, req_q & en_q & {N_MASK{~gdis_q}}, 1'b0};

    ivc_prio #(.N(N_SRC), .IW(IDX_W)) u_prio (
        .qual(qual), .any(win_any), .idx(win_idx));

    assign ack_take = ack && (state_q != ST_IDLE);

    // ---------------- flag registers ----------------
    always_comb begin
        req_d = req_q;
        if (reg_wr && reg_addr == 3'd0) req_d[7:0]  = req_q[7:0]  & reg_wdata;
        if (reg_wr && reg_addr == 3'd1) req_d[13:8] = req_q[13:8] & reg_wdata[5:0];
        if (ack_take && state_q == ST_REQ && lat_q != '0 && lat_q != IDX_BRK)
            req_d[lat_q - 4'd1] = 1'b0;
        req_d = req_d | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q      <= '0;
            en_q       <= '0;
            esel_q     <= '0;
            gdis_q     <= 1'b1;
            brk_pend_q <= 1'b0;
        end else begin
            req_q <= req_d;
            if (reg_wr && reg_addr == 3'd2) en_q[7:0]  <= reg_wdata;
            if (reg_wr && reg_addr == 3'd3) en_q[13:8] <= reg_wdata[5:0];
            if (reg_wr && reg_addr == 3'd4) begin
                gdis_q <= reg_wdata[0];
                esel_q <= reg_wdata[4:1];
            end
            if (ack_take) gdis_q <= 1'b1;
            if (ack_take && state_q == ST_REQ && lat_q == IDX_BRK) brk_pend_q <= 1'b0;
            if (brk) brk_pend_q <= 1'b1;
        end
    end

    always_comb begin
        unique case (reg_addr)
            3'd0:    reg_rdata = req_q[7:0];
            3'd1:    reg_rdata = {2'b00, req_q[13:8]};
            3'd2:    reg_rdata = en_q[7:0];
            3'd3:    reg_rdata = {2'b00, en_q[13:8]};
            3'd4:    reg_rdata = {3'b000, esel_q, gdis_q};
            default: reg_rdata = 8'h00;
        endcase
    end

    // ---------------- state machine ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RST_SVC: if (ack) state_d = ST_IDLE;                 // boot_ack
            ST_IDLE:    if (win_any) state_d = ST_REQ;              // grant
            ST_REQ:     if (ack || !qual[lat_q]) state_d = ST_IDLE; // serve / withdraw
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RST_SVC;
            lat_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && win_any) lat_q <= win_idx;
        end
    end

    always_comb begin
        irq     = (state_q != ST_IDLE);
        src_idx = (state_q == ST_RST_SVC) ? '0 : lat_q;
        vector  = vec_of(src_idx);
    end

    // ---------------- assertions ----------------
    // R7
    ack_sets_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq) |=> gdis_q);

    // R12
    vec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> (!irq || $stable(vector)));

    // R2
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && src_idx != 4'd0 && src_idx != IDX_BRK) |-> !$past(gdis_q));

    // R4
    brk_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pend_q && state_q == ST_IDLE) |=> irq);
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pin_ext = '0;
    logic [7:0]  key_in = '1;
    logic [8:0]  int_evt = '0;
    logic        brk = 1'b0, ack = 1'b0, reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq;
    logic [15:0] vector;
    logic [3:0]  src_idx;

    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_ext(pin_ext), .key_in(key_in),
        .int_evt(int_evt), .brk(brk), .ack(ack), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .vector(vector), .src_idx(src_idx));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic do_ack;
        ack = 1'b1; cyc(1); ack = 1'b0;
    endtask

    function automatic logic [15:0] exp_vec(input int idx);
        return (idx == 15) ? 16'hFFDC : 16'(32'hFFFC - 2 * idx);
    endfunction

    function automatic int evt_src(input int j);
        return (j < 8) ? j + 3 : 13;
    endfunction

    initial begin
        logic [7:0] d;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        check("R1 irq", irq, 1);
        check("R1 idx", src_idx, 0);
        check("R1 vec", vector, 16'hFFFC);
        rd(3'd4, d); check("R1 ctrl", d, 8'h01);
        rd(3'd0, d); check("R1 reqA", d, 0);
        rd(3'd3, d); check("R1 enB", d, 0);
        do_ack;
        check("R1 after ack", irq, 0);

        // R3 writing ones cannot set requests
        wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
        rd(3'd0, d); check("R3 no set A", d, 0);
        rd(3'd1, d); check("R3 no set B", d, 0);

        // R2 gating: pending but disabled
        int_evt[0] = 1'b1; cyc(1); int_evt[0] = 1'b0; cyc(3);
        check("R2 masked by dis/en", irq, 0);
        rd(3'd0, d); check("R2 req latched", d, 8'h04);
        wr(3'd4, 8'h00); cyc(3);
        check("R2 enable off", irq, 0);
        wr(3'd2, 8'hFF); wr(3'd3, 8'h3F); cyc(2);
        check("R2 all open", irq, 1);
        check("R2 idx", src_idx, 3);
        wr(3'd4, 8'h01); cyc(2);
        check("R2 withdraw on disable", irq, 0);
        wr(3'd0, 8'h00);
        rd(3'd0, d); check("R3 clear by 0", d, 0);

        // R6 R7 sweep over internal sources
        for (int j = 0; j < 9; j++) begin
            wr(3'd4, 8'h00);
            int_evt[j] = 1'b1; cyc(1); int_evt[j] = '0; cyc(2);
            check("R6 irq", irq, 1);
            check("R5 idx", src_idx, evt_src(j));
            check("R6 vector", vector, exp_vec(evt_src(j)));
            do_ack;
            check("R7 irq drop", irq, 0);
            rd(3'd4, d); check("R7 dis set", d[0], 1);
            rd(3'd0, d); check("R7 reqA cleared", d, 0);
            rd(3'd1, d); check("R7 reqB cleared", d, 0);
        end

        // R5 priority: all internal at once, served in ascending index
        int_evt = '1; cyc(1); int_evt = '0;
        for (int j = 0; j < 9; j++) begin
            wr(3'd4, 8'h00); cyc(2);
            check("R5 order", src_idx, evt_src(j));
            do_ack;
        end
        check("R5 drained", irq, 0);

        // R4 break ignores all masks
        wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        brk = 1'b1; cyc(1); brk = 1'b0; cyc(2);
        check("R4 brk irq", irq, 1);
        check("R4 brk idx", src_idx, 15);
        check("R6 brk vector", vector, 16'hFFDC);
        do_ack; cyc(2);
        check("R4 brk served", irq, 0);

        // R8 pin edges, disable held at 1
        for (int p = 0; p < 4; p++) begin
            automatic logic [2:0] a = (p < 2) ? 3'd0 : 3'd1;
            automatic logic [7:0] m = 8'(1 << ((p < 2) ? p : p));
            // falling select (0)
            pin_ext[p] = 1'b1; cyc(5);
            rd(a, d); check("R8 no req on rise (fall sel)", d & m, 0);
            pin_ext[p] = 1'b0; cyc(5);
            rd(a, d); check("R8 req on fall", d & m, m);
            wr(a, 8'h00);
            // rising select (1)
            wr(3'd4, 8'(1 | (2 << p)));
            cyc(2); wr(a, 8'h00);
            pin_ext[p] = 1'b1; cyc(5);
            rd(a, d); check("R8 req on rise", d & m, m);
            wr(a, 8'h00);
            pin_ext[p] = 1'b0; cyc(5);
            rd(a, d); check("R8 no req on fall (rise sel)", d & m, 0);
            // R9 select flip with pin high: 1->0 gives none, 0->1 gives event
            pin_ext[p] = 1'b1; cyc(5); wr(a, 8'h00);
            wr(3'd4, 8'h01); cyc(3); wr(a, 8'h00);
            wr(3'd4, 8'(1 | (2 << p))); cyc(3);
            rd(a, d); check("R9 select change raises req", d & m, m);
            wr(3'd4, 8'h01); pin_ext[p] = 1'b0; cyc(5);
            wr(a, 8'h00);
        end

        // R10 key wake-up
        key_in = 8'hFF; cyc(5);
        rd(3'd1, d); check("R10 idle", d & 8'h20, 0);
        key_in = 8'hF7; cyc(5);
        rd(3'd1, d); check("R10 fall sets", d & 8'h20, 8'h20);
        wr(3'd1, 8'h00);
        key_in = 8'hFF; cyc(5);
        rd(3'd1, d); check("R10 rise ignored", d & 8'h20, 0);

        // R11 set wins over clear in same cycle
        int_evt[1] = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h00;
        cyc(1); int_evt = '0; reg_wr = 1'b0;
        rd(3'd0, d); check("R11 set wins", d, 8'h08);
        wr(3'd0, 8'h00);

        // R12 stability against higher-priority arrival
        wr(3'd2, 8'hFF); wr(3'd3, 8'h3F);
        wr(3'd4, 8'h00);
        int_evt[2] = 1'b1; cyc(1); int_evt = '0; cyc(2);
        check("R12 first", src_idx, 5);
        int_evt[0] = 1'b1; cyc(1); int_evt = '0; cyc(3);
        check("R12 idx hold", src_idx, 5);
        check("R12 vec hold", vector, exp_vec(5));
        do_ack;
        wr(3'd4, 8'h00); cyc(2);
        check("R12 newcomer next", src_idx, 3);
        do_ack;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule